// File: doc/BRIEF.md
# Collision, Jabber and Heartbeat Controller for a Twisted-Pair Transceiver

This block decides when a 10 Mb/s twisted-pair transceiver raises its collision-presence signal toward the attached station. It watches carrier sense from the station's transmit path and from the cable's receive path. When both are active, it reports a collision. It also chooses which of the two paths feeds the data returned to the station.

A transmitter that stays on for too long is locked out. Transmission is inhibited and a collision is signalled. The lockout is released only after the transmit carrier has been quiet for a long, uninterrupted interval. When heartbeat is enabled, a short burst of collision signal follows a short gap after every normal transmission. The collision status flag stays low during that burst.

The block runs on the 10 MHz bit clock. Millisecond-scale timing comes from a one-cycle 1 ms tick. Loopback test mode turns off collision detection, jabber and heartbeat. While the link is down, collision detection is off.

Top module: `coll_guard`

## Requirements
- R1: With `link_up`=1 and `loop_mode`=0, `tx_crs`=1 together with `rx_crs`=1 drives `coll_flag`=1 and `ci_en`=1 in the same cycle. Both drop as soon as either carrier goes idle, unless another cause below holds them.
- R2: `ret_sel`=1 selects the receive path and `ret_sel`=0 selects the transmit path. `ret_sel` is 1 whenever `rx_crs`=1, including during a collision. It is 0 when only `tx_crs`=1. It keeps its last value when both carriers are idle.
- R3: Once `tx_crs` has been continuously 1 while `JAB_MS` ticks are seen, `tx_block`, `ci_en` and `coll_flag` all become 1 on the edge that samples the last of those ticks.
- R4: Lockout ends only when `UNJAB_MS` ticks are seen while `tx_crs` stays continuously 0. Ticks seen while `tx_crs`=1 do not count. Any cycle with `tx_crs`=1 restarts the count.
- R5: With `hb_enable`=1, when `tx_crs` falls outside lockout, `ci_en` is 1 after the rising edges numbered `HB_GAP`+1 through `HB_GAP`+`HB_LEN`. Edges are counted from the first one that samples `tx_crs` low, which is edge 1.
- R6: `coll_flag` stays 0 during the heartbeat burst.
- R7: If `tx_crs` returns to 1 during the heartbeat gap, that heartbeat is cancelled and no burst follows.
- R8: With `loop_mode`=1, no collision is reported, `tx_block` never sets, and no heartbeat is produced.
- R9: With `link_up`=0, simultaneous carriers do not raise `coll_flag` or `ci_en`.
- R10: After synchronous reset, `ci_en`, `tx_block`, `coll_flag` and `ret_sel` are all 0.
- R11: With `hb_enable`=0, the end of a transmission produces no `ci_en` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| tx_crs | input | 1 | Carrier sense on the station transmit path |
| rx_crs | input | 1 | Carrier sense on the cable receive path |
| hb_enable | input | 1 | Heartbeat after transmit enabled |
| loop_mode | input | 1 | Loopback test mode |
| link_up | input | 1 | Link integrity is in the pass state |
| ci_en | output | 1 | Enables the 10 MHz collision-presence pattern |
| tx_block | output | 1 | Inhibits the cable transmitter (jabber lockout) |
| coll_flag | output | 1 | Collision status indication |
| ret_sel | output | 1 | Return data source: 1 receive path, 0 transmit path |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that `loop_mode` and `link_up` change only between clock edges and never glitch within a cycle. Properties that refer to the previous cycle, such as the lockout release check, also rely on reset being synchronous. The stimulus changes every input only at falling edges, and it raises `tick_ms` for exactly one rising edge at a time. Scaled-down timing parameters keep the millisecond windows short while still counting every tick.

// File: rtl/coll_guard_pkg.sv
// Shared types for the collision / jabber / heartbeat controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package coll_guard_pkg;

    // Jabber supervisor: watching transmit length, or locked out.
    typedef enum logic [0:0] {
        JB_WATCH = 1'b0,
        JB_LOCK  = 1'b1
    } jab_state_t;

    // Heartbeat sequencer: idle, waiting the gap, emitting the burst.
    typedef enum logic [1:0] {
        HB_IDLE  = 2'd0,
        HB_WAIT  = 2'd1,
        HB_BURST = 2'd2
    } hb_state_t;

    // Width of a counter that must hold values 0..n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/cg_coll_detect.sv
// Collision detection and return-data source selection.
// Collision is combinational on the carriers so it follows them in the
// same cycle; the source select holds its last value when both are idle.
// Assumes: carriers are synchronous to clk.
module cg_coll_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_crs,
    input  logic rx_crs,
    input  logic link_up,
    input  logic loop_mode,
    output logic coll_now,
    output logic ret_sel
);

    logic sel_hold;

    // Collision: both carriers, link passing, not in loopback.
    always_comb begin
        coll_now = tx_crs & rx_crs & link_up & ~loop_mode;
    end

    // Remember the most recent active source for idle periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_hold <= 1'b0;
        end else if (rx_crs) begin
            sel_hold <= 1'b1;
        end else if (tx_crs) begin
            sel_hold <= 1'b0;
        end
    end

    // Receive path wins whenever it carries data, else transmit, else hold.
    always_comb begin
        if (rx_crs) begin
            ret_sel = 1'b1;
        end else if (tx_crs) begin
            ret_sel = 1'b0;
        end else begin
            ret_sel = sel_hold;
        end
    end

endmodule

// File: rtl/cg_jabber.sv
// Jabber supervisor. Counts millisecond ticks while the transmit carrier
// is continuously active; after JAB_MS of them it locks the transmitter
// out. Lockout ends after UNJAB_MS ticks of uninterrupted transmit idle.
// Assumes: tick_ms is a single-cycle pulse; loop_mode disables the
// supervisor and clears any lockout.
module cg_jabber
    import coll_guard_pkg::*;
#(
    parameter int JAB_MS   = 50,
    parameter int UNJAB_MS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic tx_crs,
    input  logic loop_mode,
    output logic locked
);

    localparam int MAXC = (JAB_MS > UNJAB_MS) ? JAB_MS : UNJAB_MS;
    localparam int CW   = cnt_width(MAXC);
    localparam logic [CW-1:0] JAB_LAST   = CW'(JAB_MS - 1);
    localparam logic [CW-1:0] UNJAB_LAST = CW'(UNJAB_MS - 1);

    jab_state_t    state;
    logic [CW-1:0] cnt;

    // State and tick counter update.
    always_ff @(posedge clk) begin
        if (!rst_n || loop_mode) begin
            state <= JB_WATCH;
            cnt   <= '0;
        end else begin
            case (state)
                JB_WATCH: begin
                    if (!tx_crs) begin
                        cnt <= '0;
                    end else if (tick_ms) begin
                        if (cnt == JAB_LAST) begin
                            state <= JB_LOCK;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                JB_LOCK: begin
                    if (tx_crs) begin
                        cnt <= '0;
                    end else if (tick_ms) begin
                        if (cnt == UNJAB_LAST) begin
                            state <= JB_WATCH;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    state <= JB_WATCH;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Lockout indication.
    always_comb begin
        locked = (state == JB_LOCK);
    end

endmodule

// File: rtl/cg_heartbeat.sv
// Post-transmit heartbeat sequencer. After the transmit carrier falls
// (outside lockout, with heartbeat enabled) it waits HB_GAP bit times
// and then emits a burst HB_LEN bit times long. A new transmit start
// during the wait cancels the pending burst.
// Assumes: tx_crs is synchronous to clk.
module cg_heartbeat
    import coll_guard_pkg::*;
#(
    parameter int HB_GAP = 10,
    parameter int HB_LEN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_crs,
    input  logic hb_enable,
    input  logic loop_mode,
    input  logic jab_locked,
    output logic burst
);

    localparam int MAXC = (HB_GAP > HB_LEN) ? HB_GAP : HB_LEN;
    localparam int CW   = cnt_width(MAXC);
    localparam logic [CW-1:0] GAP_LAST = CW'(HB_GAP - 1);
    localparam logic [CW-1:0] LEN_LAST = CW'(HB_LEN - 1);

    hb_state_t     state;
    logic [CW-1:0] cnt;
    logic          tx_q;
    logic          tx_end;

    // Delayed carrier for end-of-transmit detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= 1'b0;
        end else begin
            tx_q <= tx_crs;
        end
    end

    // Qualified end of a normal transmission.
    always_comb begin
        tx_end = tx_q & ~tx_crs & hb_enable & ~loop_mode & ~jab_locked;
    end

    // Gap and burst sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || loop_mode) begin
            state <= HB_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                HB_IDLE: begin
                    if (tx_end) begin
                        state <= HB_WAIT;
                        cnt   <= '0;
                    end
                end
                HB_WAIT: begin
                    if (tx_crs) begin
                        state <= HB_IDLE;
                        cnt   <= '0;
                    end else if (cnt == GAP_LAST) begin
                        state <= HB_BURST;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                HB_BURST: begin
                    if (cnt == LEN_LAST) begin
                        state <= HB_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= HB_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Burst indication.
    always_comb begin
        burst = (state == HB_BURST);
    end

endmodule

// File: rtl/coll_guard.sv
// Top of the collision-presence controller. Merges collision, jabber
// lockout and heartbeat into the collision-pattern enable, and drives
// the transmit inhibit, the collision flag and the return-data select.
// The collision flag excludes the heartbeat burst.
// Assumes: all inputs synchronous to clk; tick_ms one cycle wide.
module coll_guard #(
    parameter int JAB_MS   = 50,
    parameter int UNJAB_MS = 500,
    parameter int HB_GAP   = 10,
    parameter int HB_LEN   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic tx_crs,
    input  logic rx_crs,
    input  logic hb_enable,
    input  logic loop_mode,
    input  logic link_up,
    output logic ci_en,
    output logic tx_block,
    output logic coll_flag,
    output logic ret_sel
);

    logic coll_now;
    logic jab_locked;
    logic hb_burst;

    cg_coll_detect u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_crs    (tx_crs),
        .rx_crs    (rx_crs),
        .link_up   (link_up),
        .loop_mode (loop_mode),
        .coll_now  (coll_now),
        .ret_sel   (ret_sel)
    );

    cg_jabber #(
        .JAB_MS   (JAB_MS),
        .UNJAB_MS (UNJAB_MS)
    ) u_jabber (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_ms   (tick_ms),
        .tx_crs    (tx_crs),
        .loop_mode (loop_mode),
        .locked    (jab_locked)
    );

    cg_heartbeat #(
        .HB_GAP (HB_GAP),
        .HB_LEN (HB_LEN)
    ) u_heartbeat (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_crs     (tx_crs),
        .hb_enable  (hb_enable),
        .loop_mode  (loop_mode),
        .jab_locked (jab_locked),
        .burst      (hb_burst)
    );

    // Output merge: flag excludes heartbeat, pattern enable includes it.
    always_comb begin
        tx_block  = jab_locked;
        coll_flag = coll_now | jab_locked;
        ci_en     = coll_now | jab_locked | hb_burst;
    end

endmodule

// File: rtl/coll_guard_chk.sv
// Property checker for coll_guard, attached by bind.
// Assumes: inputs synchronous to clk, synchronous active-low reset.
module coll_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_crs,
    input logic rx_crs,
    input logic loop_mode,
    input logic link_up,
    input logic ci_en,
    input logic tx_block,
    input logic coll_flag,
    input logic ret_sel
);

    assert_coll_seen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_crs && rx_crs && link_up && !loop_mode) |-> (coll_flag && ci_en));

    assert_flag_has_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
        coll_flag |-> ci_en);

    assert_rx_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_crs |-> ret_sel);

    assert_lock_signals_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_block |-> (ci_en && coll_flag));

    assert_release_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_block) && $past(rst_n) && !$past(loop_mode)) |-> !$past(tx_crs));

    assert_loop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_mode && $past(loop_mode) && $past(rst_n)) |-> (!tx_block && !coll_flag && !ci_en));

    assert_link_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_up && !tx_block) |-> !coll_flag);

    assert_burst_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ci_en && !tx_crs && !rx_crs && !tx_block) |-> !coll_flag);

endmodule

bind coll_guard coll_guard_chk u_coll_guard_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_crs    (tx_crs),
    .rx_crs    (rx_crs),
    .loop_mode (loop_mode),
    .link_up   (link_up),
    .ci_en     (ci_en),
    .tx_block  (tx_block),
    .coll_flag (coll_flag),
    .ret_sel   (ret_sel)
);

// File: tb/test_coll_guard.sv
// Self-checking bench for coll_guard with scaled-down timing.
module test_coll_guard;

    localparam int CLK_PERIOD = 100;
    localparam int T_JAB   = 3;
    localparam int T_UNJAB = 5;
    localparam int T_GAP   = 4;
    localparam int T_LEN   = 3;
    localparam int WATCHDOG_CYCLES = 100000;

    // Vector fields: [7]tx [6]rx [5]link [4]loop [3]coll [2]ci [1]sel [0]spare
    localparam int NVEC = 10;
    localparam logic [7:0] VEC [NVEC] = '{
        8'b1010_0000,  // tx only
        8'b1110_1110,  // collision
        8'b1010_0000,  // rx drops, tx remains
        8'b1110_1110,  // collision again
        8'b0110_0010,  // tx drops, rx remains
        8'b0010_0010,  // both idle, select held
        8'b1100_0010,  // link down, no collision
        8'b1111_0010,  // loopback, no collision
        8'b0110_0010,  // rx only
        8'b1010_0000   // tx only
    };

    logic clk = 1'b0;
    logic rst_n, tick_ms, tx_crs, rx_crs, hb_enable, loop_mode, link_up;
    logic ci_en, tx_block, coll_flag, ret_sel;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coll_guard #(
        .JAB_MS   (T_JAB),
        .UNJAB_MS (T_UNJAB),
        .HB_GAP   (T_GAP),
        .HB_LEN   (T_LEN)
    ) i_coll_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_ms   (tick_ms),
        .tx_crs    (tx_crs),
        .rx_crs    (rx_crs),
        .hb_enable (hb_enable),
        .loop_mode (loop_mode),
        .link_up   (link_up),
        .ci_en     (ci_en),
        .tx_block  (tx_block),
        .coll_flag (coll_flag),
        .ret_sel   (ret_sel)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick_ms = 1'b1;
        @(negedge clk); tick_ms = 1'b0;
        #1;
    endtask

    // Checks heartbeat window after a transmit fall already driven.
    task automatic watch_window(input string tag, input bit expect_burst);
        for (int k = 1; k <= T_GAP + T_LEN + 2; k++) begin
            @(negedge clk); #1;
            check(tag, ci_en, expect_burst && (k >= T_GAP + 1) && (k <= T_GAP + T_LEN));
            check({tag, " flag"}, coll_flag, 1'b0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG_CYCLES && !done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick_ms = 1'b0; tx_crs = 1'b0; rx_crs = 1'b0;
        hb_enable = 1'b0; loop_mode = 1'b0; link_up = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R10 ci_en reset", ci_en, 1'b0);
        check("R10 tx_block reset", tx_block, 1'b0);
        check("R10 coll_flag reset", coll_flag, 1'b0);
        check("R10 ret_sel reset", ret_sel, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // Table walk: collision path and source select (R1, R2, R8, R9).
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            tx_crs = VEC[v][7]; rx_crs = VEC[v][6];
            link_up = VEC[v][5]; loop_mode = VEC[v][4];
            #1;
            check($sformatf("R1 coll_flag vec %0d", v), coll_flag, VEC[v][3]);
            check($sformatf("R1 ci_en vec %0d", v), ci_en, VEC[v][2]);
            check($sformatf("R2 ret_sel vec %0d", v), ret_sel, VEC[v][1]);
        end

        // Jabber lockout (R3) and release (R4).
        @(negedge clk);
        tx_crs = 1'b1; rx_crs = 1'b0; link_up = 1'b1; loop_mode = 1'b0; hb_enable = 1'b0;
        pulse_tick(); pulse_tick();
        check("R3 no lock before limit", tx_block, 1'b0);
        pulse_tick();
        check("R3 tx_block at limit", tx_block, 1'b1);
        check("R3 ci_en at limit", ci_en, 1'b1);
        check("R3 coll_flag at limit", coll_flag, 1'b1);
        for (int t = 0; t < T_UNJAB + 1; t++) pulse_tick();
        check("R4 active ticks do not release", tx_block, 1'b1);
        @(negedge clk); tx_crs = 1'b0;
        for (int t = 0; t < T_UNJAB - 1; t++) pulse_tick();
        check("R4 held before full idle", tx_block, 1'b1);
        check("R4 pattern during lock", ci_en, 1'b1);
        @(negedge clk); tx_crs = 1'b1;
        @(negedge clk); tx_crs = 1'b0;
        for (int t = 0; t < T_UNJAB - 1; t++) pulse_tick();
        check("R4 restart on carrier", tx_block, 1'b1);
        pulse_tick();
        check("R4 released", tx_block, 1'b0);
        check("R4 ci_en released", ci_en, 1'b0);

        // Heartbeat timing (R5) with flag quiet (R6).
        @(negedge clk); hb_enable = 1'b1; tx_crs = 1'b1;
        @(negedge clk); tx_crs = 1'b0;
        watch_window("R5 R6 heartbeat", 1'b1);

        // Cancellation by new transmit during the gap (R7).
        @(negedge clk); tx_crs = 1'b1;
        @(negedge clk); tx_crs = 1'b0;
        @(negedge clk);
        @(negedge clk); tx_crs = 1'b1;
        watch_window("R7 cancelled", 1'b0);
        @(negedge clk); tx_crs = 1'b0;
        repeat (T_GAP + T_LEN + 3) @(negedge clk);

        // Heartbeat disabled (R11).
        @(negedge clk); hb_enable = 1'b0; tx_crs = 1'b1;
        @(negedge clk); tx_crs = 1'b0;
        watch_window("R11 disabled", 1'b0);

        // Loopback disables everything (R8).
        @(negedge clk); loop_mode = 1'b1; hb_enable = 1'b1; tx_crs = 1'b1; rx_crs = 1'b1;
        #1;
        check("R8 no collision in loop", coll_flag, 1'b0);
        for (int t = 0; t < T_JAB + 2; t++) pulse_tick();
        check("R8 no lock in loop", tx_block, 1'b0);
        @(negedge clk); tx_crs = 1'b0; rx_crs = 1'b0;
        watch_window("R8 no heartbeat in loop", 1'b0);
        @(negedge clk); loop_mode = 1'b0;

        // Reset clears an active lockout (R10).
        @(negedge clk); tx_crs = 1'b1;
        for (int t = 0; t < T_JAB; t++) pulse_tick();
        check("R3 locked before reset", tx_block, 1'b1);
        @(negedge clk); rst_n = 1'b0; tx_crs = 1'b0;
        @(negedge clk); #1;
        check("R10 lock cleared by reset", tx_block, 1'b0);
        check("R10 ci_en cleared by reset", ci_en, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule